// File: doc/BRIEF.md
# Atomic Synchronization Memory

This block is a small shared word memory reachable from several requester ports. Each port can issue plain loads and stores, and also the two common kinds of atomic primitive. The first is compare-and-swap: an address, an expected value and a replacement value. The second is a linked pair: a linked load takes a reservation, and a later conditional store succeeds only if that reservation is still intact. Software uses these primitives to build locks, counters and lock-free queues that several cores share.

All ports share one arbiter. In each cycle at most one request is accepted, and the lowest-numbered requesting port always wins. The chosen operation reads the addressed word, decides whether it writes, and updates the reservations, all in that same cycle. Because of this, no other access can fall between the read and the write of an atomic operation.

Each port keeps one reservation, which covers a line of four words. Any write that lands in a reserved line removes the reservations that other ports hold on that line. The response arrives one cycle after acceptance. It carries the word as it was before the operation, and a success flag.

Top module: `atomic_sync_mem`

## Requirements
- R1: After reset every memory word reads as zero, no port holds a reservation, and all `resp_valid` bits are low.
- R2: In any cycle `req_ready` is asserted for at most one port: the lowest-indexed port whose `req_valid` is high. Exactly one operation is performed per accepting cycle.
- R3: A port accepted in cycle t sees its `resp_valid` bit high in cycle t+1 and at no other time for that request. `resp_rdata` then holds the word stored at the address before the operation.
- R4: Op code 0 (load) returns the word with `resp_ok`=1 and changes nothing. Op codes 5, 6 and 7 behave exactly like a load.
- R5: Op code 1 (store) writes `req_wdata` to the address and returns `resp_ok`=1.
- R6: Op code 2 (compare-and-swap) writes `req_wdata` only if the stored word equals `req_cmp`. It returns `resp_ok`=1 when it writes and 0 otherwise, and it always returns the previous word.
- R7: Op code 3 (linked load) returns the word with `resp_ok`=1 and gives the port a reservation on the line of that address. This replaces any reservation the port held before.
- R8: Op code 4 (conditional store) writes `req_wdata` and returns `resp_ok`=1 only if the port holds a reservation on the addressed line. Otherwise it returns 0 and leaves memory unchanged.
- R9: Every conditional store removes the issuing port's reservation, whether it succeeds or fails.
- R10: Any write (a store, a successful compare-and-swap or a successful conditional store) clears the reservations of all other ports on the written line. A port's own store does not clear its own reservation.
- R11: A line is the set of four words that share address bits [ADDR_W-1:2]. A write to a different line leaves a reservation untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | PORTS | Request present, one bit per port |
| req_ready | output | PORTS | Request accepted this cycle |
| req_op | input | 3*PORTS | Operation code per port |
| req_addr | input | ADDR_W*PORTS | Word address per port |
| req_wdata | input | DATA_W*PORTS | Store, swap or conditional-store data |
| req_cmp | input | DATA_W*PORTS | Expected value for compare-and-swap |
| resp_valid | output | PORTS | Response present, one bit per port |
| resp_rdata | output | DATA_W*PORTS | Word held before the operation |
| resp_ok | output | PORTS | Success flag, qualified by resp_valid |

## Verification
The assertions check several properties on every cycle. At most one port is accepted and at most one response is returned. Port 0 is never made to wait. An accepted request is always answered in the next cycle. A load or a failed compare-and-swap leaves its word unchanged, and a conditional store without a matching reservation reports failure. Other behaviours need a sequence of operations to show up, and only the bench scenarios cover them. These include a reservation lost to another port's write in the same line, a reservation that survives a write to a neighbouring line, replacement by a second linked load, and the ordering of contended requests. The behavioural model follows all of these and is compared against the outputs on every clock.

// File: rtl/atomic_sync_mem.sv
module atomic_sync_mem #(
  parameter int PORTS  = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORTS-1:0]         req_valid,
  output logic [PORTS-1:0]         req_ready,
  input  logic [3*PORTS-1:0]       req_op,
  input  logic [ADDR_W*PORTS-1:0]  req_addr,
  input  logic [DATA_W*PORTS-1:0]  req_wdata,
  input  logic [DATA_W*PORTS-1:0]  req_cmp,
  output logic [PORTS-1:0]         resp_valid,
  output logic [DATA_W*PORTS-1:0]  resp_rdata,
  output logic [PORTS-1:0]         resp_ok
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LINE_W = 2;
  localparam int LA_W   = ADDR_W - LINE_W;
  localparam int GW     = (PORTS > 1) ? $clog2(PORTS) : 1;

  localparam logic [2:0] OP_ST  = 3'd1;
  localparam logic [2:0] OP_CAS = 3'd2;
  localparam logic [2:0] OP_LL  = 3'd3;
  localparam logic [2:0] OP_SC  = 3'd4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PORTS-1:0]  rsv_v;
  logic [LA_W-1:0]   rsv_line [PORTS];

  logic [2:0]        op_p   [PORTS];
  logic [ADDR_W-1:0] addr_p [PORTS];
  logic [DATA_W-1:0] wd_p   [PORTS];
  logic [DATA_W-1:0] cmp_p  [PORTS];

  for (genvar i = 0; i < PORTS; i++) begin : g_split
    assign op_p[i]   = req_op[3*i +: 3];
    assign addr_p[i] = req_addr[ADDR_W*i +: ADDR_W];
    assign wd_p[i]   = req_wdata[DATA_W*i +: DATA_W];
    assign cmp_p[i]  = req_cmp[DATA_W*i +: DATA_W];
  end

  logic          found;
  logic [GW-1:0] gsel;

  always_comb begin
    found     = 1'b0;
    gsel      = '0;
    req_ready = '0;
    for (int i = 0; i < PORTS; i++) begin
      if (req_valid[i] && !found) begin
        found        = 1'b1;
        gsel         = GW'(i);
        req_ready[i] = 1'b1;
      end
    end
  end

  logic [2:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] cur, wdata, cmp;
  logic [LA_W-1:0]   line;
  logic              rsv_hit, wr, ok;

  assign op      = op_p[gsel];
  assign addr    = addr_p[gsel];
  assign wdata   = wd_p[gsel];
  assign cmp     = cmp_p[gsel];
  assign cur     = mem[addr];
  assign line    = addr[ADDR_W-1:LINE_W];
  assign rsv_hit = rsv_v[gsel] && (rsv_line[gsel] == line);

  always_comb begin
    wr = 1'b0;
    ok = 1'b1;
    case (op)
      OP_ST:  wr = 1'b1;
      OP_CAS: begin ok = (cur == cmp); wr = ok; end
      OP_SC:  begin ok = rsv_hit;      wr = ok; end
      default: ;
    endcase
    wr = wr && found;
  end

  logic [DATA_W-1:0] rdata_q;
  logic              ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      rsv_v      <= '0;
      resp_valid <= '0;
      rdata_q    <= '0;
      ok_q       <= 1'b0;
      for (int i = 0; i < PORTS; i++) rsv_line[i] <= '0;
    end else begin
      resp_valid <= req_ready;
      rdata_q    <= cur;
      ok_q       <= ok;
      if (wr) mem[addr] <= wdata;
      for (int i = 0; i < PORTS; i++) begin
        if (found && gsel == GW'(i)) begin
          if (op == OP_LL) begin
            rsv_v[i]    <= 1'b1;
            rsv_line[i] <= line;
          end else if (op == OP_SC) begin
            rsv_v[i] <= 1'b0;
          end
        end else if (wr && rsv_line[i] == line) begin
          rsv_v[i] <= 1'b0;
        end
      end
    end
  end

  assign resp_rdata = {PORTS{rdata_q}};
  assign resp_ok    = resp_valid & {PORTS{ok_q}};

  AST_ONE_GRANT:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)); // R2
  AST_PORT0_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) req_valid[0] |-> req_ready[0]); // R2
  AST_ONE_RESP:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(resp_valid)); // R3
  AST_RESP_NEXT:    assert property (@(posedge clk) disable iff (!rst_n) (|req_ready) |=> (|resp_valid)); // R3
  AST_LOAD_KEEPS:   assert property (@(posedge clk) disable iff (!rst_n)
                      (found && op == 3'd0) |=> mem[$past(addr)] == $past(cur)); // R4
  AST_CAS_MISS:     assert property (@(posedge clk) disable iff (!rst_n)
                      (found && op == OP_CAS && cur != cmp) |=> mem[$past(addr)] == $past(cur)); // R6
  AST_SC_NO_RSV:    assert property (@(posedge clk) disable iff (!rst_n)
                      (found && op == OP_SC && !rsv_hit) |=> resp_ok == '0); // R8
endmodule

// File: tb/tb_atomic_sync_mem.sv
module tb_atomic_sync_mem;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    rv = '0;
  logic [N-1:0]    rdy;
  logic [3*N-1:0]  rop = '0;
  logic [AW*N-1:0] raddr = '0;
  logic [DW*N-1:0] rwd = '0;
  logic [DW*N-1:0] rcmp = '0;
  logic [N-1:0]    rsp_v;
  logic [DW*N-1:0] rsp_d;
  logic [N-1:0]    rsp_ok;

  atomic_sync_mem #(.PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_ready(rdy), .req_op(rop),
    .req_addr(raddr), .req_wdata(rwd), .req_cmp(rcmp), .resp_valid(rsp_v),
    .resp_rdata(rsp_d), .resp_ok(rsp_ok));

  int compared = 0, mismatched = 0;
  bit done = 0;
  int mem_m [1 << AW];
  bit rsv_m [N];
  int line_m [N];
  logic [DW-1:0] last_rd;
  logic last_ok;

  task automatic chk(bit good, string req, longint act, longint exp);
    compared++;
    if (!good) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      1: return "R5 store";
      2: return "R6 cas";
      3: return "R7 linked load";
      4: return "R8 cond store";
      default: return "R4 load";
    endcase
  endfunction

  task automatic tick();
    int g, op, a, line;
    logic [DW-1:0] wd, cm, cur;
    bit ok, wr;
    logic [N-1:0] er;
    #1;
    g = -1;
    for (int i = 0; i < N; i++) if (rv[i] && g < 0) g = i;
    er = (g >= 0) ? (N'(1) << g) : '0;
    chk(rdy == er, "R2 ready", rdy, er);
    ok = 1; cur = '0; op = 0;
    if (g >= 0) begin
      op = int'(rop[g*3 +: 3]);
      a = int'(raddr[g*AW +: AW]);
      wd = rwd[g*DW +: DW];
      cm = rcmp[g*DW +: DW];
      cur = mem_m[a];
      line = a >> 2;
      wr = 0;
      case (op)
        1: wr = 1;
        2: begin ok = (cur == cm); wr = ok; end
        3: begin rsv_m[g] = 1; line_m[g] = line; end
        4: begin ok = rsv_m[g] && line_m[g] == line; wr = ok; rsv_m[g] = 0; end
        default: ;
      endcase
      if (wr) begin
        mem_m[a] = int'(wd);
        for (int j = 0; j < N; j++) if (j != g && rsv_m[j] && line_m[j] == line) rsv_m[j] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_v == er, "R3 resp_valid", rsp_v, er);
    if (g >= 0) begin
      last_rd = rsp_d[g*DW +: DW];
      last_ok = rsp_ok[g];
      chk(last_rd == cur, {tag_of(op), " rdata"}, last_rd, cur);
      chk(last_ok == ok, {tag_of(op), " ok"}, last_ok, ok);
      rv[g] = 1'b0;
    end
  endtask

  task automatic put(int p, int op, int a, int wd, int cm);
    rop[p*3 +: 3]    = 3'(op);
    raddr[p*AW +: AW] = AW'(a);
    rwd[p*DW +: DW]  = DW'(wd);
    rcmp[p*DW +: DW] = DW'(cm);
    rv[p] = 1'b1;
  endtask

  task automatic drain();
    while (|rv) tick();
  endtask

  task automatic op1(int p, int op, int a, int wd, int cm);
    put(p, op, a, wd, cm);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < (1 << AW); k++) mem_m[k] = 0;
    for (int i = 0; i < N; i++) begin rsv_m[i] = 0; line_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rsp_v == '0, "R1 resp_valid after reset", rsp_v, 0);
    op1(0, 0, 9, 0, 0);
    chk(last_rd == 0, "R1 memory cleared", last_rd, 0);
    op1(1, 4, 9, 5, 0);
    chk(last_ok == 0, "R1 no reservation at reset", last_ok, 0);

    op1(0, 1, 3, 32'h1234, 0);
    op1(2, 6, 3, 0, 0);
    chk(last_rd == 32'h1234, "R5 store then R4 odd-code load", last_rd, 32'h1234);

    op1(1, 2, 3, 77, 32'h1234);
    chk(last_ok == 1, "R6 cas hit ok", last_ok, 1);
    op1(1, 2, 3, 88, 32'h1234);
    chk(last_ok == 0 && last_rd == 77, "R6 cas miss returns old", last_rd, 77);
    op1(0, 0, 3, 0, 0);
    chk(last_rd == 77, "R6 cas miss left word", last_rd, 77);

    op1(0, 3, 4, 0, 0);
    op1(0, 4, 6, 11, 0);
    chk(last_ok == 1, "R8 cond store same line succeeds", last_ok, 1);
    op1(0, 4, 6, 12, 0);
    chk(last_ok == 0, "R9 reservation gone after cond store", last_ok, 0);

    op1(0, 3, 4, 0, 0);
    op1(1, 1, 7, 99, 0);
    op1(0, 4, 5, 13, 0);
    chk(last_ok == 0, "R10 other port write kills reservation", last_ok, 0);
    op1(2, 0, 5, 0, 0);
    chk(last_rd == 0, "R8 failed cond store left memory", last_rd, 0);

    op1(0, 3, 4, 0, 0);
    op1(1, 1, 8, 3, 0);
    op1(0, 4, 4, 14, 0);
    chk(last_ok == 1, "R11 write to next line keeps reservation", last_ok, 1);

    op1(2, 3, 12, 0, 0);
    op1(2, 3, 20, 0, 0);
    op1(2, 4, 12, 1, 0);
    chk(last_ok == 0, "R7 second linked load replaced first", last_ok, 0);

    op1(1, 3, 20, 0, 0);
    op1(1, 1, 21, 4, 0);
    op1(1, 4, 22, 6, 0);
    chk(last_ok == 1, "R10 own store keeps own reservation", last_ok, 1);

    put(2, 1, 30, 2, 0); put(1, 1, 30, 1, 0); put(0, 1, 30, 0, 0);
    drain();
    op1(1, 0, 30, 0, 0);
    chk(last_rd == 2, "R2 priority order last write port 2", last_rd, 2);

    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < N; p++)
        if (!rv[p] && $urandom_range(0, 1) == 1)
          put(p, $urandom_range(0, 7), $urandom_range(0, 15),
              $urandom_range(0, 3), $urandom_range(0, 3));
      tick();
    end
    drain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule